// File: doc/BRIEF.md
# MESIF Snooping Coherence Controller

This block tracks the coherence state of a small set of cache lines held by several private caches that share one snooping bus, using the five-state MESIF protocol. Each cache raises a request (read, write or invalidate) for a line. A fixed-priority arbiter grants one request per cycle. In the same clock edge, the controller commits the new state of every cache's copy of that line.

For each committed transaction the block reports who supplies the data: nobody, memory, or one peer cache. When a peer with dirty data gives it up, the block also raises a write-back strobe. The Forward state lets exactly one sharer answer a miss. That role moves to the most recent requester, so Shared copies never drive the bus. Data payloads, tag lookup, replacement and memory timing are handled elsewhere. An eviction reaches the block as an invalidate request from the owning cache.

Top module: `mesif_coherence`

## Requirements
- R1: After reset every copy of every line is Invalid, with the state encoding Invalid=0, Shared=1, Exclusive=2, Forward=3, Modified=4. In that state `done`, `src_kind`, `src_id`, `wb_strobe` and `gnt` are all zero.
- R2: Among valid requests, the lowest-numbered cache wins, and `gnt` is one-hot for that cycle. The transaction commits at the next rising edge. For the following cycle only, `done` is 1 and `src_kind` shows the data source: 0 = none, 1 = memory, 2 = the peer named in `src_id`. Operation codes are 0 = no-op, 1 = read, 2 = write, 3 = invalidate.
- R3: A read from a cache that already holds a valid copy changes no state and reports source none.
- R4: A read miss with no other valid copy of the line is served by memory, and the requester enters Exclusive.
- R5: A read miss while a peer holds Forward is served by that peer. The peer drops to Shared, the requester enters Forward, and Shared copies do not change.
- R6: A read miss while a peer holds Exclusive or Modified is served by that peer. The peer drops to Shared and the requester enters Forward. A Modified supplier also pulses `wb_strobe`.
- R7: A read miss while the line has only Shared copies and no Forward copy is served by memory, and the requester enters Forward.
- R8: A write moves the requester to Modified and every other copy to Invalid in the same transaction. If the requester held no valid copy, the data comes from a Modified peer (with `wb_strobe`), otherwise from a Forward or Exclusive peer, otherwise from memory. If the requester already held a valid copy, the source is none.
- R9: An invalidate moves only the requester's copy to Invalid and reports source none. It pulses `wb_strobe` when that copy was Modified.
- R10: At any time no line has two Forward copies, and a Modified copy is never accompanied by any other valid copy.
- R11: A granted no-op pulses `done` with source none and leaves all states unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | NCACHE | Per-cache request valid, held until granted |
| req_op | input | 2*NCACHE | Per-cache operation code, cache c at bits [2c+1:2c] |
| req_line | input | LW*NCACHE | Per-cache line index, cache c at bits [LW*c +: LW] |
| gnt | output | NCACHE | One-hot bus grant for the current cycle |
| done | output | 1 | A transaction committed at the last edge |
| src_kind | output | 2 | Data source of the committed transaction |
| src_id | output | IDW | Supplying peer when `src_kind` is 2, else 0 |
| wb_strobe | output | 1 | Dirty data is being written back |
| st_all | output | 3*NLINE*NCACHE | State of line l in cache c at bits [3*(l*NCACHE+c) +: 3] |

## Verification
On every cycle, the assertions check the line-state invariants (a single Forward copy, and Modified held alone), the one-hot grant, the priority of the lowest-numbered requester, and that a grant is always followed by a `done` pulse. Which peer supplies data, the exact state each copy moves to, and the write-back pulses depend on the history of the line. Only the bench shows these. It replays directed sequences that walk one line through every transition, plus a long pseudo-random mix of operations across caches and lines, and compares each result with its own protocol model.

// File: rtl/mesif_pkg.sv
package mesif_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_F = 3'd3,
    ST_M = 3'd4
  } cstate_e;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2,
    OP_INV = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_PEER = 2'd2
  } src_e;
endpackage

// File: rtl/mesif_arb.sv
module mesif_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] win,
  output logic          any
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    gnt = '0;
    win = '0;
    any = |req;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) win = IW'(i);
    end
    if (any) gnt[win] = 1'b1;
  end
endmodule

// File: rtl/mesif_resolve.sv
module mesif_resolve
  import mesif_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int SW = 3
) (
  input  logic [N*SW-1:0] cur,
  input  logic [IW-1:0]   rid,
  input  logic [1:0]      op,
  output logic [N*SW-1:0] nxt,
  output logic [1:0]      kind,
  output logic [IW-1:0]   sid,
  output logic            wb
);
  logic [SW-1:0] own;
  logic          m_hit, e_hit, f_hit, s_hit;
  logic [IW-1:0] m_id, e_id, f_id;

  // summary of the other caches' copies
  always_comb begin
    own   = cur[rid*SW +: SW];
    m_hit = 1'b0; e_hit = 1'b0; f_hit = 1'b0; s_hit = 1'b0;
    m_id  = '0;   e_id  = '0;   f_id  = '0;
    for (int i = 0; i < N; i++) begin
      if (IW'(i) != rid) begin
        case (cur[i*SW +: SW])
          ST_M:    begin m_hit = 1'b1; m_id = IW'(i); end
          ST_E:    begin e_hit = 1'b1; e_id = IW'(i); end
          ST_F:    begin f_hit = 1'b1; f_id = IW'(i); end
          ST_S:    s_hit = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    nxt  = cur;
    kind = SRC_NONE;
    sid  = '0;
    wb   = 1'b0;
    case (op)
      OP_RD: begin
        if (own == ST_I) begin
          nxt[rid*SW +: SW] = ST_F;
          kind = SRC_PEER;
          if (m_hit) begin
            sid = m_id; wb = 1'b1; nxt[m_id*SW +: SW] = ST_S;
          end else if (e_hit) begin
            sid = e_id; nxt[e_id*SW +: SW] = ST_S;
          end else if (f_hit) begin
            sid = f_id; nxt[f_id*SW +: SW] = ST_S;
          end else begin
            kind = SRC_MEM;
            if (!s_hit) nxt[rid*SW +: SW] = ST_E;
          end
        end
      end
      OP_WR: begin
        for (int i = 0; i < N; i++) nxt[i*SW +: SW] = ST_I;
        nxt[rid*SW +: SW] = ST_M;
        if (own == ST_I) begin
          kind = SRC_PEER;
          if (m_hit) begin
            sid = m_id; wb = 1'b1;
          end else if (f_hit) begin
            sid = f_id;
          end else if (e_hit) begin
            sid = e_id;
          end else begin
            kind = SRC_MEM;
          end
        end
      end
      OP_INV: begin
        nxt[rid*SW +: SW] = ST_I;
        wb = (own == ST_M);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mesif_line_reg.sv
module mesif_line_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/mesif_coherence.sv
module mesif_coherence
  import mesif_pkg::*;
#(
  parameter int NCACHE = 4,
  parameter int NLINE  = 4,
  localparam int IDW = (NCACHE > 1) ? $clog2(NCACHE) : 1,
  localparam int LW  = (NLINE > 1) ? $clog2(NLINE) : 1,
  localparam int SW  = 3,
  localparam int VW  = NCACHE * SW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCACHE-1:0]         req_vld,
  input  logic [NCACHE*2-1:0]       req_op,
  input  logic [NCACHE*LW-1:0]      req_line,
  output logic [NCACHE-1:0]         gnt,
  output logic                      done,
  output logic [1:0]                src_kind,
  output logic [IDW-1:0]            src_id,
  output logic                      wb_strobe,
  output logic [NLINE*VW-1:0]       st_all
);
  logic [1:0]              rsync_q;
  logic                    rst_i_n;
  logic [IDW-1:0]          win_id;
  logic                    win_any;
  logic [1:0]              sel_op;
  logic [LW-1:0]           sel_line;
  logic [NLINE-1:0][VW-1:0] st_q;
  logic [VW-1:0]           cur_v, nxt_v;
  logic [1:0]              res_kind;
  logic [IDW-1:0]          res_id;
  logic                    res_wb;
  logic                    done_d, wb_d;
  logic [1:0]              kind_d;
  logic [IDW-1:0]          id_d;

  // reset: asserted at once, released on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  mesif_arb #(.N(NCACHE)) u_arb (
    .req (req_vld & {NCACHE{rst_i_n}}),
    .gnt (gnt),
    .win (win_id),
    .any (win_any)
  );

  always_comb begin
    sel_op   = req_op[win_id*2 +: 2];
    sel_line = req_line[win_id*LW +: LW];
    cur_v    = st_q[sel_line];
  end

  mesif_resolve #(.N(NCACHE)) u_res (
    .cur  (cur_v),
    .rid  (win_id),
    .op   (sel_op),
    .nxt  (nxt_v),
    .kind (res_kind),
    .sid  (res_id),
    .wb   (res_wb)
  );

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    logic line_en;
    assign line_en = win_any && (sel_line == LW'(l));
    mesif_line_reg #(.W(VW)) u_reg (
      .clk   (clk),
      .rst_n (rst_i_n),
      .en    (line_en),
      .d     (nxt_v),
      .q     (st_q[l])
    );
  end

  assign st_all = st_q;

  // result next-state
  always_comb begin
    done_d = win_any;
    kind_d = win_any ? res_kind : SRC_NONE;
    id_d   = win_any ? res_id   : '0;
    wb_d   = win_any && res_wb;
  end

  // result register
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done      <= 1'b0;
      src_kind  <= '0;
      src_id    <= '0;
      wb_strobe <= 1'b0;
    end else begin
      done      <= done_d;
      src_kind  <= kind_d;
      src_id    <= id_d;
      wb_strobe <= wb_d;
    end
  end
endmodule

// File: rtl/mesif_coherence_chk.sv
module mesif_coherence_chk #(
  parameter int NCACHE = 4,
  parameter int NLINE  = 4,
  localparam int SW = 3,
  localparam int VW = NCACHE * SW
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NCACHE-1:0]   req_vld,
  input logic [NCACHE-1:0]   gnt,
  input logic                done,
  input logic [1:0]          src_kind,
  input logic                wb_strobe,
  input logic [NLINE*VW-1:0] st_all
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R2
  AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n) (req_vld[0] && (|gnt)) |-> gnt[0]); // R2
  AST_GNT_DONE: assert property (@(posedge clk) disable iff (!rst_n) (|gnt) |=> done); // R2
  AST_SRC_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) (src_kind != 2'd0 || wb_strobe) |-> done); // R2

  for (genvar l = 0; l < NLINE; l++) begin : g_inv
    logic [NCACHE-1:0] f_v, m_v, v_v;
    always_comb begin
      for (int c = 0; c < NCACHE; c++) begin
        f_v[c] = st_all[(l*NCACHE+c)*SW +: SW] == 3'd3;
        m_v[c] = st_all[(l*NCACHE+c)*SW +: SW] == 3'd4;
        v_v[c] = st_all[(l*NCACHE+c)*SW +: SW] != 3'd0;
      end
    end
    AST_ONE_FORWARD: assert property (@(posedge clk) disable iff (!rst_n) $countones(f_v) <= 1); // R10
    AST_M_ALONE: assert property (@(posedge clk) disable iff (!rst_n) (|m_v) |-> ($countones(v_v) == 1)); // R10
  end
endmodule

bind mesif_coherence mesif_coherence_chk #(.NCACHE(NCACHE), .NLINE(NLINE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .gnt       (gnt),
  .done      (done),
  .src_kind  (src_kind),
  .wb_strobe (wb_strobe),
  .st_all    (st_all)
);

// File: tb/mesif_coherence_tb.sv
module mesif_coherence_tb;
  localparam int NC = 4;
  localparam int NL = 4;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0]    req_vld = '0;
  logic [NC*2-1:0]  req_op = '0;
  logic [NC*LW-1:0] req_line = '0;
  logic [NC-1:0]    gnt;
  logic             done;
  logic [1:0]       src_kind;
  logic [1:0]       src_id;
  logic             wb_strobe;
  logic [NL*NC*3-1:0] st_all;

  int nchk = 0;
  int nfail = 0;
  int st_m [NL][NC];

  always #4 clk = ~clk;

  mesif_coherence #(.NCACHE(NC), .NLINE(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
    .req_line(req_line), .gnt(gnt), .done(done), .src_kind(src_kind),
    .src_id(src_id), .wb_strobe(wb_strobe), .st_all(st_all)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // protocol model written from the requirements
  task automatic model(input int c, input int op, input int ln,
                       output int k, output int id, output int wb, output string tg);
    int own, mi, ei, fi;
    bit sany;
    k = 0; id = 0; wb = 0; tg = "R11";
    own = st_m[ln][c];
    mi = -1; ei = -1; fi = -1; sany = 0;
    for (int j = 0; j < NC; j++) begin
      if (j != c) begin
        if (st_m[ln][j] == 4) mi = j;
        if (st_m[ln][j] == 2) ei = j;
        if (st_m[ln][j] == 3) fi = j;
        if (st_m[ln][j] == 1) sany = 1;
      end
    end
    if (op == 1) begin
      if (own != 0) tg = "R3";
      else if (mi >= 0) begin tg = "R6"; k = 2; id = mi; wb = 1; st_m[ln][mi] = 1; st_m[ln][c] = 3; end
      else if (ei >= 0) begin tg = "R6"; k = 2; id = ei; st_m[ln][ei] = 1; st_m[ln][c] = 3; end
      else if (fi >= 0) begin tg = "R5"; k = 2; id = fi; st_m[ln][fi] = 1; st_m[ln][c] = 3; end
      else if (sany)    begin tg = "R7"; k = 1; st_m[ln][c] = 3; end
      else              begin tg = "R4"; k = 1; st_m[ln][c] = 2; end
    end else if (op == 2) begin
      tg = "R8";
      if (own == 0) begin
        if (mi >= 0)      begin k = 2; id = mi; wb = 1; end
        else if (fi >= 0) begin k = 2; id = fi; end
        else if (ei >= 0) begin k = 2; id = ei; end
        else k = 1;
      end
      for (int j = 0; j < NC; j++) st_m[ln][j] = 0;
      st_m[ln][c] = 4;
    end else if (op == 3) begin
      tg = "R9";
      wb = (own == 4) ? 1 : 0;
      st_m[ln][c] = 0;
    end
  endtask

  task automatic check_states(input string tg);
    for (int l = 0; l < NL; l++) begin
      int nf;
      nf = 0;
      for (int c = 0; c < NC; c++) begin
        int a;
        a = int'(st_all[(l*NC+c)*3 +: 3]);
        if (a == 3) nf++;
        chk(a == st_m[l][c], tg, a, st_m[l][c]);
      end
      chk(nf <= 1, "R10", nf, 1);
    end
  endtask

  // called at the negedge right after the commit edge
  task automatic check_result(input int c, input int op, input int ln);
    int k, id, wb;
    string tg;
    model(c, op, ln, k, id, wb, tg);
    #1;
    chk(done == 1'b1, "R2", int'(done), 1);
    chk(int'(src_kind) == k, tg, int'(src_kind), k);
    chk(int'(src_id) == id, tg, int'(src_id), id);
    chk(int'(wb_strobe) == wb, tg, int'(wb_strobe), wb);
    check_states(tg);
  endtask

  task automatic do_req(input int c, input int op, input int ln);
    @(negedge clk);
    req_vld = '0;
    req_vld[c] = 1'b1;
    req_op[c*2 +: 2] = 2'(op);
    req_line[c*LW +: LW] = LW'(ln);
    #1 chk(gnt == NC'(1 << c), "R2", int'(gnt), 1 << c);
    @(negedge clk);
    req_vld = '0;
    check_result(c, op, ln);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < NC; c++) st_m[l][c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check_states("R1");
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(src_kind == 2'd0, "R1", int'(src_kind), 0);
    chk(wb_strobe == 1'b0, "R1", int'(wb_strobe), 0);
    chk(gnt == '0, "R1", int'(gnt), 0);

    // directed walk of line 0
    do_req(0, 1, 0);   // R4 memory, Exclusive
    do_req(1, 1, 0);   // R6 from Exclusive
    do_req(2, 1, 0);   // R5 from Forward
    do_req(2, 1, 0);   // R3 hit
    do_req(2, 3, 0);   // R9 Forward evicted
    do_req(3, 1, 0);   // R7 only Shared left
    do_req(3, 2, 0);   // R8 upgrade
    do_req(0, 1, 0);   // R6 from Modified, write-back
    do_req(1, 0, 0);   // R11 no-op
    do_req(2, 2, 1);   // R8 write from memory
    do_req(2, 3, 1);   // R9 dirty eviction

    // R2 priority: caches 1 and 3 request together
    @(negedge clk);
    req_vld = 4'b1010;
    req_op[1*2 +: 2] = 2'd1; req_line[1*LW +: LW] = 2'd2;
    req_op[3*2 +: 2] = 2'd1; req_line[3*LW +: LW] = 2'd2;
    #1 chk(gnt == 4'b0010, "R2", int'(gnt), 2);
    @(negedge clk);
    req_vld[1] = 1'b0;
    check_result(1, 1, 2);
    chk(gnt == 4'b1000, "R2", int'(gnt), 8);
    @(negedge clk);
    req_vld = '0;
    check_result(3, 1, 2);

    // pseudo-random sweep over caches, operations and lines
    lf = 16'hACE1;
    for (int it = 0; it < 1500; it++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_req(int'(lf[1:0]), int'(lf[3:2]), int'(lf[5:4]));
    end

    @(negedge clk);
    #1 chk(done == 1'b0, "R2", int'(done), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule